// File: doc/BRIEF.md
# Adaptive Transversal Filter with Least-Mean-Squares Weight Update

This block is a transversal FIR filter whose tap weights are not fixed. Each time a sample is accepted, the block forms the filter output from the current weights and the most recent inputs. It subtracts that output from a desired (reference) sample to get an error. It then moves every weight one gradient step along the product of the error and the input that the weight multiplies. Typical uses are system identification, echo or noise cancellation and channel equalisation. In these the desired sample is the signal the filter should learn to reproduce.

The step size is a power of two. The product of error and input is arithmetically shifted right by `MU_SHIFT` before it is added to a weight. The result saturates at the signed weight range. The output accumulator is wide enough that no sum of products can overflow. A synchronous clear returns all weights to zero. The current weights are visible on a flat output bus.

Top module: `lms_adaptive_filter`

## Requirements
- R1: After reset, `outValid` is 0, `yOut` and `eOut` are 0, every weight is 0 and every stored past sample is 0.
- R2: For an accepted sample n, the output is y(n) = sum over k = 0..TAPS-1 of w_k · x(n−k). Here x(n) is the sample on `xIn` in that cycle, which is tap 0. Tap k holds the k-th earlier accepted sample, or 0 if fewer samples have arrived. All values are signed two's complement.
- R3: The error is e(n) = d(n) − y(n), computed at full width (ERR_W bits), with d(n) the signed value on `dIn`.
- R4: After sample n, each weight becomes w_k + ((e(n) · x(n−k)) >>> MU_SHIFT), where >>> is an arithmetic right shift that rounds toward minus infinity.
- R5: y(n) and e(n) use the weights as they stood before the update caused by sample n.
- R6: A weight update that would leave the signed WEIGHT_W range is clamped to 2^(WEIGHT_W−1)−1 or −2^(WEIGHT_W−1).
- R7: A sample is accepted when `inValid` is 1 and `clearW` is 0. `outValid` is 1 in exactly the cycle after an accepted sample, and `yOut` and `eOut` for that sample are valid then and hold until the next accepted sample.
- R8: While `inValid` is 0, the weights, the stored past samples and `yOut`/`eOut` all hold their values.
- R9: `clearW` = 1 zeroes every weight at the next clock edge. It takes priority over `inValid`: that cycle's sample is dropped, no output is produced and the stored past samples keep their values.
- R10: `wFlat` carries weight k in bits [k·WEIGHT_W +: WEIGHT_W], with weight 0 in the least significant field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| clearW | input | 1 | Synchronous weight clear, priority over inValid |
| inValid | input | 1 | Sample strobe for xIn and dIn |
| xIn | input | DATA_W | Signed input sample |
| dIn | input | DATA_W | Signed desired sample |
| outValid | output | 1 | yOut/eOut updated for the last accepted sample |
| yOut | output | ACC_W = DATA_W+WEIGHT_W+clog2(TAPS) | Signed filter output |
| eOut | output | ACC_W+1 | Signed error d − y |
| wFlat | output | TAPS·WEIGHT_W | Current weights, weight 0 in the low field |

## Verification
A single wrong weight or a stale past sample corrupts `yOut` and `eOut` one cycle after the next accepted sample. It then spreads through the feedback into every weight on the following updates. That is why `wFlat` is compared field by field after each sample, which catches an update fault before it can mix into other taps. A wrong step shift or a clamp that wraps shows up as a weight that differs from the integer model of the recursion. The long saturation run is there to drive the weights to their limits.

// File: rtl/lms_pkg.sv
package lms_pkg;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic loadOut;    // capture y and e
    logic shiftLine;  // push xIn into the past-sample line
    logic adaptW;     // write the updated weights
    logic wipeW;      // force all weights to zero
  } lms_strobe_t;

endpackage

// File: rtl/lms_ctrl.sv
module lms_ctrl
  import lms_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clearW,
  input  logic        inValid,
  output lms_strobe_t strb,
  output logic        outValid
);

  logic accept;

  assign accept = inValid && !clearW;

  always_comb begin
    strb           = '0;
    strb.wipeW     = clearW;
    strb.loadOut   = accept;
    strb.shiftLine = accept;
    strb.adaptW    = accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= accept;
  end

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !clearW) |=> outValid);  // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && !clearW) |=> !outValid);  // R7

endmodule

// File: rtl/lms_datapath.sv
module lms_datapath
  import lms_pkg::*;
#(
  parameter int TAPS     = 4,
  parameter int DATA_W   = 8,
  parameter int WEIGHT_W = 12,
  parameter int MU_SHIFT = 8,
  localparam int ACC_W   = DATA_W + WEIGHT_W + $clog2(TAPS),
  localparam int ERR_W   = ACC_W + 1
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  lms_strobe_t                strb,
  input  logic signed [DATA_W-1:0]   xIn,
  input  logic signed [DATA_W-1:0]   dIn,
  output logic signed [ACC_W-1:0]    yOut,
  output logic signed [ERR_W-1:0]    eOut,
  output logic [TAPS*WEIGHT_W-1:0]   wFlat
);

  localparam int MULT_W = DATA_W + WEIGHT_W;
  localparam int PROD_W = ERR_W + DATA_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [WEIGHT_W-1:0] W_MAX = {1'b0, {(WEIGHT_W-1){1'b1}}};
  localparam logic signed [WEIGHT_W-1:0] W_MIN = {1'b1, {(WEIGHT_W-1){1'b0}}};

  logic signed [DATA_W-1:0]   lineQ   [TAPS-1];
  logic signed [DATA_W-1:0]   tapVec  [TAPS];
  logic signed [WEIGHT_W-1:0] wQ      [TAPS];
  logic signed [WEIGHT_W-1:0] wNext   [TAPS];
  logic signed [MULT_W-1:0]   mulTerm [TAPS];
  logic signed [PROD_W-1:0]   grad    [TAPS];
  logic signed [PROD_W-1:0]   stepK   [TAPS];
  logic signed [SUM_W-1:0]    cand    [TAPS];
  logic signed [ACC_W-1:0]    accSum;
  logic signed [ERR_W-1:0]    errNow;

  // tap 0 is the sample arriving now, the rest come from the line
  assign tapVec[0] = xIn;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tapVec[k] = lineQ[k-1];
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_lane
    assign mulTerm[k] = MULT_W'(wQ[k]) * MULT_W'(tapVec[k]);
    assign grad[k]    = PROD_W'(errNow) * PROD_W'(tapVec[k]);
    assign stepK[k]   = grad[k] >>> MU_SHIFT;
    assign cand[k]    = SUM_W'(wQ[k]) + SUM_W'(stepK[k]);
    assign wNext[k]   = (cand[k] > SUM_W'(W_MAX)) ? W_MAX :
                        (cand[k] < SUM_W'(W_MIN)) ? W_MIN :
                        WEIGHT_W'(cand[k]);
    assign wFlat[k*WEIGHT_W +: WEIGHT_W] = wQ[k];
  end

  always_comb begin
    accSum = '0;
    for (int k = 0; k < TAPS; k++) accSum = accSum + ACC_W'(mulTerm[k]);
  end

  assign errNow = ERR_W'(dIn) - ERR_W'(accSum);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++)     wQ[k]    <= '0;
      for (int k = 0; k < TAPS - 1; k++) lineQ[k] <= '0;
      yOut <= '0;
      eOut <= '0;
    end else begin
      if (strb.wipeW) begin
        for (int k = 0; k < TAPS; k++) wQ[k] <= '0;
      end else if (strb.adaptW) begin
        for (int k = 0; k < TAPS; k++) wQ[k] <= wNext[k];
      end
      if (strb.shiftLine) begin
        lineQ[0] <= xIn;
        for (int k = 1; k < TAPS - 1; k++) lineQ[k] <= lineQ[k-1];
      end
      if (strb.loadOut) begin
        yOut <= accSum;
        eOut <= errNow;
      end
    end
  end

  AST_WEIGHTS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.adaptW && !strb.wipeW) |=> $stable(wFlat));  // R8
  AST_WIPE_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipeW |=> (wFlat == '0));  // R9
  AST_OUT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadOut |=> ($stable(yOut) && $stable(eOut)));  // R8

endmodule

// File: rtl/lms_adaptive_filter.sv
module lms_adaptive_filter
  import lms_pkg::*;
#(
  parameter int TAPS     = 4,
  parameter int DATA_W   = 8,
  parameter int WEIGHT_W = 12,
  parameter int MU_SHIFT = 8,
  localparam int ACC_W   = DATA_W + WEIGHT_W + $clog2(TAPS),
  localparam int ERR_W   = ACC_W + 1
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clearW,
  input  logic                     inValid,
  input  logic [DATA_W-1:0]        xIn,
  input  logic [DATA_W-1:0]        dIn,
  output logic                     outValid,
  output logic [ACC_W-1:0]         yOut,
  output logic [ERR_W-1:0]         eOut,
  output logic [TAPS*WEIGHT_W-1:0] wFlat
);

  lms_strobe_t strb;
  logic signed [ACC_W-1:0] ySig;
  logic signed [ERR_W-1:0] eSig;

  lms_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clearW   (clearW),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  lms_datapath #(
    .TAPS     (TAPS),
    .DATA_W   (DATA_W),
    .WEIGHT_W (WEIGHT_W),
    .MU_SHIFT (MU_SHIFT)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .xIn   ($signed(xIn)),
    .dIn   ($signed(dIn)),
    .yOut  (ySig),
    .eOut  (eSig),
    .wFlat (wFlat)
  );

  assign yOut = ySig;
  assign eOut = eSig;

  AST_ERR_MATCHES_DESIRED: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($signed(eOut) ==
                  ERR_W'($signed($past(dIn))) - ERR_W'($signed(yOut))));  // R3

endmodule

// File: tb/lms_adaptive_filter_test.sv
`timescale 1ns/1ps
module lms_adaptive_filter_test;

  localparam int TAPS = 4, DW = 8, WW = 12, MU = 8;
  localparam int ACCW = DW + WW + $clog2(TAPS);
  localparam int ERRW = ACCW + 1;
  localparam longint WMAX = (1 <<< (WW - 1)) - 1;
  localparam longint WMIN = -(1 <<< (WW - 1));
  localparam int NVEC = 16;
  localparam int VEC_X [NVEC] = '{ 10, -20, 35, 7, -64, 100, -3, 0,
                                   127, -128, 45, -45, 12, 90, -77, 5 };
  localparam int VEC_D [NVEC] = '{ 30, -10, 60, 20, -100, 80, 15, -5,
                                   100, -90, 40, -60, 0, 70, -50, 25 };

  logic clk = 0, rstN = 0, clearW = 0, inValid = 0;
  logic [DW-1:0] xIn = '0, dIn = '0;
  logic outValid;
  logic [ACCW-1:0] yOut;
  logic [ERRW-1:0] eOut;
  logic [TAPS*WW-1:0] wFlat;

  int testCnt = 0, failCnt = 0;
  bit done = 0, sawSat = 0;

  longint mW [TAPS];
  longint mLine [TAPS-1];
  longint expY = 0, expE = 0;

  always #2 clk = ~clk;

  lms_adaptive_filter #(.TAPS(TAPS), .DATA_W(DW), .WEIGHT_W(WW), .MU_SHIFT(MU)) uut (
    .clk(clk), .rstN(rstN), .clearW(clearW), .inValid(inValid),
    .xIn(xIn), .dIn(dIn), .outValid(outValid), .yOut(yOut), .eOut(eOut), .wFlat(wFlat));

  function automatic longint dutW(int k);
    return longint'($signed(wFlat[k*WW +: WW]));
  endfunction

  task automatic check(string req, longint act, longint exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkWeights(string req);
    for (int k = 0; k < TAPS; k++) begin
      check(req, dutW(k), mW[k]);
      if (dutW(k) == WMAX || dutW(k) == WMIN) sawSat = 1;
    end
  endtask

  // integer reference of the recursion: R2 R3 R4 R5 R6
  task automatic modelStep(longint x, longint d);
    longint tv [TAPS];
    longint s;
    tv[0] = x;
    for (int k = 1; k < TAPS; k++) tv[k] = mLine[k-1];
    expY = 0;
    for (int k = 0; k < TAPS; k++) expY += mW[k] * tv[k];
    expE = d - expY;
    for (int k = 0; k < TAPS; k++) begin
      s = mW[k] + ((expE * tv[k]) >>> MU);
      if (s > WMAX) s = WMAX;
      if (s < WMIN) s = WMIN;
      mW[k] = s;
    end
    for (int k = TAPS - 2; k > 0; k--) mLine[k] = mLine[k-1];
    mLine[0] = x;
  endtask

  // starts and ends at a falling edge
  task automatic sample(int x, int d, string req);
    xIn = DW'(x); dIn = DW'(d); inValid = 1;
    modelStep(x, d);
    @(negedge clk);
    inValid = 0;
    check({req, " R7 outValid"}, longint'(outValid), 1);
    check({req, " R2 R5 y"}, longint'($signed(yOut)), expY);
    check({req, " R3 e"}, longint'($signed(eOut)), expE);
    checkWeights({req, " R4 R6 R10 w"});
  endtask

  initial begin
    for (int k = 0; k < TAPS; k++) mW[k] = 0;
    for (int k = 0; k < TAPS - 1; k++) mLine[k] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 outValid", longint'(outValid), 0);
    check("R1 y", longint'($signed(yOut)), 0);
    check("R1 e", longint'($signed(eOut)), 0);
    checkWeights("R1 w");

    // table walk
    for (int i = 0; i < NVEC; i++) sample(VEC_X[i], VEC_D[i], "table");

    // R8 hold while inValid low
    xIn = 8'd55; dIn = 8'hF7;
    repeat (3) begin
      @(negedge clk);
      check("R8 R7 outValid idle", longint'(outValid), 0);
      check("R8 y held", longint'($signed(yOut)), expY);
      check("R8 e held", longint'($signed(eOut)), expE);
      checkWeights("R8 w held");
    end
    sample(-33, 12, "R8 line held");
    sample(64, -64, "R8 after idle");

    // R9 clear with priority over inValid
    clearW = 1; inValid = 1; xIn = 8'd99; dIn = 8'd5;
    @(negedge clk);
    clearW = 0; inValid = 0;
    for (int k = 0; k < TAPS; k++) mW[k] = 0;
    check("R9 outValid dropped", longint'(outValid), 0);
    check("R9 y unchanged", longint'($signed(yOut)), expY);
    checkWeights("R9 w cleared");
    sample(40, 90, "R9 first after clear");
    sample(-50, 30, "R9 second after clear");
    sample(20, -70, "R9 third after clear");

    // R6 drive to saturation
    for (int i = 0; i < 14; i++) sample(127, 127, "R6 sat run");
    for (int i = 0; i < 6; i++) sample(-128, 100, "R6 sat neg");
    check("R6 saturation reached", longint'(sawSat), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule